// File: doc/BRIEF.md
# Serial EEPROM Slave (Level-Update Driven)

This block models a 256-byte two-wire serial EEPROM target that a host drives by presenting new clock and data line levels one pair at a time, for example from a software bit-bang register. It has no bus clock of its own. Each time an update strobe is asserted, the slave compares the new (SCL, SDA) pair with the pair it stored on the previous update. From that comparison it detects start conditions, stop conditions and clocked bits. It stores the SDA level it presents back to the host.

A transfer has the following steps. A start condition opens the transfer. Eight bits of command follow, and the slave acknowledges them. Eight bits of word address follow, and the slave acknowledges again once it has fetched the addressed byte. During the address phase of a read command, the slave shifts out the byte it latched at the end of the previous transfer, most significant bit first. The contents are a fixed preset image. The slave does not write to them and does not match a device address.

A single tick counter sequences the command phase and the address phase. The counter returns to its idle value once the address has been taken.

Top module: `serial_eeprom_slave`

## Requirements
- R1: After synchronous reset, `sda_out` is 1 and the slave is idle: the stored SCL and SDA levels are both 1, and the counter, command, address, data and pending-acknowledge state are all cleared.
- R2: State and `sda_out` change only on clock cycles where `upd_valid` is 1. Line levels presented while `upd_valid` is 0 have no effect.
- R3: A start condition restarts command reception, even in the middle of a transfer. A start condition is an update where the stored SCL is 1, the new SCL is 1, the stored SDA is 1 and the new SDA is 0.
- R4: While the slave is idle with no acknowledge pending, every update other than a start condition is ignored. Clocked bits are not counted and no acknowledge is produced.
- R5: A bit is accepted only on a rising SCL update (stored SCL 0, new SCL 1) whose new SDA equals the stored SDA. A rising update on which SDA also changes is discarded and is not counted.
- R6: Command bits enter MSB first. Once 8 command bits are accepted, the next rising SCL update drives `sda_out` to 0 as an acknowledge and shifts no bit. The last command bit selects the direction: 1 means read, 0 means write.
- R7: For a read command, each of the 8 address-bit rising updates sets `sda_out` to the next bit of the byte latched at the end of the previous transfer, MSB first. After reset that byte is 0x00.
- R8: After 8 address bits, the slave latches the byte at that address and acknowledges on the next rising SCL update by driving `sda_out` to 0. It is then idle.
- R9: The preset contents are as follows, with all other bytes zero, including every byte above 0x7F:
  - 0x00–0x06: 80 08 04 0D 0A 01 40
  - 0x08–0x0A: 01 75 54
  - 0x0C, 0x0D, 0x0F: 82, 08, 01
  - 0x10–0x14: 8F 04 02 01 01
  - 0x16: 0E
  - 0x1B–0x1F: 14 0F 14 2D 40
  - 0x20–0x23: 15 08 15 08
  - 0x3E–0x3F: 12 D0
  - 0x7E–0x7F: 64 F4
- R10: On every accepted update that does not force an acknowledge or a read bit, `sda_out` takes the new SDA level. This includes write-command address bits and updates while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_valid | input | 1 | Marks a new line-level pair on `scl_in`/`sda_in` |
| scl_in | input | 1 | New SCL level |
| sda_in | input | 1 | New SDA level driven by the host |
| sda_out | output | 1 | Stored SDA level presented by the slave |

## Verification
Three functions can fall on the same rising SCL update: the acknowledge override, bit acceptance and read-data output. The acknowledge override takes priority, so the clock that follows the eighth bit of each phase must read 0 and must not advance the phase. The bench provokes this in every transfer, including one transfer that carries a discarded skewed bit, so that a miscounted bit moves the acknowledge by one clock. A start condition can also coincide with a transfer already in progress. The bench judges this case by counting exactly eight further command bits before the acknowledge.

// File: rtl/seep_pkg.sv
package seep_pkg;

    parameter int BYTE_W = 8;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_START,
        EV_STOP,
        EV_RISE_BIT,
        EV_RISE_SKEW
    } bus_ev_e;

    typedef struct packed {
        logic scl;
        logic sda;
    } bus_lvl_t;

    // Fixed preset image; every index not listed reads as zero.
    function automatic logic [BYTE_W-1:0] preset_byte(input logic [15:0] idx);
        logic [BYTE_W-1:0] v;
        case (idx)
            16'h0000: v = 8'h80;
            16'h0001: v = 8'h08;
            16'h0002: v = 8'h04;
            16'h0003: v = 8'h0D;
            16'h0004: v = 8'h0A;
            16'h0005: v = 8'h01;
            16'h0006: v = 8'h40;
            16'h0008: v = 8'h01;
            16'h0009: v = 8'h75;
            16'h000A: v = 8'h54;
            16'h000C: v = 8'h82;
            16'h000D: v = 8'h08;
            16'h000F: v = 8'h01;
            16'h0010: v = 8'h8F;
            16'h0011: v = 8'h04;
            16'h0012: v = 8'h02;
            16'h0013: v = 8'h01;
            16'h0014: v = 8'h01;
            16'h0016: v = 8'h0E;
            16'h001B: v = 8'h14;
            16'h001C: v = 8'h0F;
            16'h001D: v = 8'h14;
            16'h001E: v = 8'h2D;
            16'h001F: v = 8'h40;
            16'h0020: v = 8'h15;
            16'h0021: v = 8'h08;
            16'h0022: v = 8'h15;
            16'h0023: v = 8'h08;
            16'h003E: v = 8'h12;
            16'h003F: v = 8'hD0;
            16'h007E: v = 8'h64;
            16'h007F: v = 8'hF4;
            default:  v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/seep_event_decode.sv
module seep_event_decode
    import seep_pkg::*;
(
    input  bus_lvl_t prev,
    input  bus_lvl_t cur,
    output bus_ev_e  ev
);

    logic both_high;
    logic rising;

    assign both_high = prev.scl & cur.scl;
    assign rising    = ~prev.scl & cur.scl;

    always_comb begin
        ev = EV_NONE;
        if (both_high && (prev.sda != cur.sda)) begin
            ev = cur.sda ? EV_STOP : EV_START;
        end else if (rising) begin
            ev = (prev.sda == cur.sda) ? EV_RISE_BIT : EV_RISE_SKEW;
        end
    end

endmodule

// File: rtl/seep_preset_rom.sv
module seep_preset_rom
    import seep_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [BYTE_W-1:0] rd_data
);

    always_comb begin
        rd_data = preset_byte(16'(addr));
    end

endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
    import seep_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CMD_W  = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic upd_valid,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_out
);

    localparam int DATA_W  = BYTE_W;
    localparam int CMD_END = CMD_W + 1;
    localparam int ADR_END = CMD_END + ADDR_W;
    localparam int TICK_W  = $clog2(ADR_END + 1);

    typedef struct packed {
        logic [TICK_W-1:0] tick;
        logic [CMD_W-1:0]  cmd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              ack;
        bus_lvl_t          lvl;
    } slave_st_t;

    slave_st_t st, nx;
    bus_lvl_t  cur;
    bus_ev_e   ev;
    logic [ADDR_W-1:0] addr_shift;
    logic [DATA_W-1:0] rom_q;
    logic idle;
    logic rise;

    assign cur.scl = scl_in;
    assign cur.sda = sda_in;

    seep_event_decode u_decode (
        .prev (st.lvl),
        .cur  (cur),
        .ev   (ev)
    );

    assign addr_shift = {st.addr[ADDR_W-2:0], sda_in};

    seep_preset_rom #(.ADDR_W(ADDR_W)) u_rom (
        .addr    (addr_shift),
        .rd_data (rom_q)
    );

    assign idle = (st.tick == '0) && !st.ack;
    assign rise = (ev == EV_RISE_BIT) || (ev == EV_RISE_SKEW);

    always_comb begin
        nx = st;
        if (upd_valid) begin
            nx.lvl = cur;
            if (ev == EV_START) begin
                nx.tick = TICK_W'(1);
                nx.cmd  = '0;
            end else if (ev == EV_STOP || idle) begin
                nx.tick = st.tick;
            end else if (rise) begin
                if (st.ack) begin
                    nx.lvl.sda = 1'b0;
                    nx.ack     = 1'b0;
                end else if (ev == EV_RISE_BIT) begin
                    if (st.tick < TICK_W'(CMD_END)) begin
                        nx.cmd  = {st.cmd[CMD_W-2:0], sda_in};
                        nx.tick = st.tick + TICK_W'(1);
                        if (st.tick == TICK_W'(CMD_END - 1)) begin
                            nx.ack = 1'b1;
                        end
                    end else if (st.tick < TICK_W'(ADR_END)) begin
                        if (st.cmd[0]) begin
                            nx.lvl.sda = st.data[DATA_W-1];
                        end
                        nx.addr = addr_shift;
                        nx.data = {st.data[DATA_W-2:0], 1'b0};
                        if (st.tick == TICK_W'(ADR_END - 1)) begin
                            nx.data = rom_q;
                            nx.ack  = 1'b1;
                            nx.tick = '0;
                        end else begin
                            nx.tick = st.tick + TICK_W'(1);
                        end
                    end else begin
                        nx.lvl.sda = 1'b0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st.tick    <= '0;
            st.cmd     <= '0;
            st.addr    <= '0;
            st.data    <= '0;
            st.ack     <= 1'b0;
            st.lvl.scl <= 1'b1;
            st.lvl.sda <= 1'b1;
        end else begin
            st <= nx;
        end
    end

    assign sda_out = st.lvl.sda;

    // R2: nothing moves without an update strobe
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !upd_valid |=> $stable(st));

    // R3: start condition restarts command reception
    a_r3_start: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && ev == EV_START) |=> (st.tick == TICK_W'(1) && st.cmd == '0));

    // R4: idle slave ignores all but a start
    a_r4_idle: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && st.tick == '0 && !st.ack && ev != EV_START)
        |=> (st.tick == '0 && !st.ack));

    // R6: pending acknowledge pulls the line low and is consumed
    a_r6_ack_low: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && st.ack && rise) |=> (!sda_out && !st.ack));

    // R7: read command presents the latched data MSB
    a_r7_read_bit: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && ev == EV_RISE_BIT && !st.ack && st.cmd[0]
         && st.tick >= TICK_W'(CMD_END) && st.tick < TICK_W'(ADR_END))
        |=> (sda_out == $past(st.data[DATA_W-1])));

    // R8: last address bit returns the counter to idle with ack pending
    a_r8_wrap: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && ev == EV_RISE_BIT && !st.ack && st.tick == TICK_W'(ADR_END - 1))
        |=> (st.tick == '0 && st.ack));

    // R10: non-rising updates store the host level as presented
    a_r10_follow: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && !rise) |=> (sda_out == $past(sda_in)));

endmodule

// File: tb/serial_eeprom_slave_tb.sv
module serial_eeprom_slave_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam int NTV        = 9;

    // {command, word address, expected byte seen on sda_out during address phase}
    localparam logic [23:0] TV [NTV] = '{
        24'hA1_00_00,   // read after reset: latched byte 0x00 (R7)
        24'hA1_3E_80,   // shows byte 0x00 = 0x80 (R9)
        24'hA1_7F_12,   // shows byte 0x3E = 0x12 (R9)
        24'hA1_01_F4,   // shows byte 0x7F = 0xF4 (R9)
        24'hA0_FF_FF,   // write: line follows host bits (R10)
        24'hA1_10_00,   // shows byte 0xFF = 0x00 (R9)
        24'hA1_80_8F,   // shows byte 0x10 = 0x8F (R9)
        24'hA1_09_00,   // shows byte 0x80 = 0x00 (R9)
        24'hA1_00_75    // shows byte 0x09 = 0x75 (R9)
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic upd_valid = 1'b0;
    logic scl_in = 1'b1;
    logic sda_in = 1'b1;
    logic sda_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    serial_eeprom_slave u_dut (
        .clk       (clk),
        .rst       (rst),
        .upd_valid (upd_valid),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_out   (sda_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic upd(input logic s, input logic d);
        @(negedge clk);
        upd_valid = 1'b1;
        scl_in    = s;
        sda_in    = d;
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    task automatic start_cond();
        upd(1'b0, 1'b1);
        upd(1'b1, 1'b1);
        upd(1'b1, 1'b0);
    endtask

    task automatic stop_cond();
        upd(1'b0, 1'b0);
        upd(1'b1, 1'b0);
        upd(1'b1, 1'b1);
    endtask

    task automatic send_bit(input logic b, output logic o);
        upd(1'b0, b);
        upd(1'b1, b);
        o = sda_out;
    endtask

    task automatic ack_clk(output logic o);
        upd(1'b0, 1'b1);
        upd(1'b1, 1'b1);
        o = sda_out;
    endtask

    task automatic xfer(input logic [7:0] cmd, input logic [7:0] adr,
                        input logic [7:0] exp, input string tag);
        logic o;
        logic [7:0] got;
        start_cond();
        for (int i = 7; i >= 0; i--) send_bit(cmd[i], o);
        ack_clk(o);
        check("R6 command ack", {7'b0, o}, 8'h00);
        for (int i = 7; i >= 0; i--) begin
            send_bit(adr[i], o);
            got[i] = o;
        end
        check(tag, got, exp);
        ack_clk(o);
        check("R8 address ack", {7'b0, o}, 8'h00);
        stop_cond();
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic o;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset line level", {7'b0, sda_out}, 8'h01);

        // R2: levels presented without the strobe are ignored
        scl_in = 1'b0; sda_in = 1'b0;
        @(negedge clk);
        scl_in = 1'b1; sda_in = 1'b0;
        @(negedge clk);
        scl_in = 1'b1; sda_in = 1'b1;
        @(negedge clk);
        scl_in = 1'b1; sda_in = 1'b0;
        @(negedge clk);
        check("R2 no strobe no change", {7'b0, sda_out}, 8'h01);

        // R4/R1: no start, nine clocked ones: no acknowledge ever appears
        for (int i = 0; i < 9; i++) send_bit(1'b1, o);
        check("R4 idle ignores bits", {7'b0, sda_out}, 8'h01);
        // R10: idle line follows host level
        upd(1'b0, 1'b0);
        check("R10 idle follows sda", {7'b0, sda_out}, 8'h00);

        // main table
        for (int i = 0; i < NTV; i++) begin
            xfer(TV[i][23:16], TV[i][15:8], TV[i][7:0],
                 TV[i][16] ? "R7 R9 read byte" : "R10 write follows");
        end

        // R8: after a finished transfer the slave is idle again
        for (int i = 0; i < 9; i++) send_bit(1'b1, o);
        check("R8 idle after transfer", {7'b0, sda_out}, 8'h01);

        // R3: restart in the middle of a command
        start_cond();
        send_bit(1'b1, o);
        send_bit(1'b0, o);
        send_bit(1'b1, o);
        start_cond();
        for (int i = 7; i >= 0; i--) send_bit(((8'hA0 >> i) & 8'h01) != 0, o);
        ack_clk(o);
        check("R3 restart then ack", {7'b0, o}, 8'h00);
        for (int i = 0; i < 8; i++) send_bit(1'b0, o);
        ack_clk(o);
        check("R3 address ack after restart", {7'b0, o}, 8'h00);
        stop_cond();

        // R5: a skewed rising edge is discarded
        start_cond();
        send_bit(1'b1, o);
        send_bit(1'b0, o);
        send_bit(1'b1, o);
        upd(1'b0, 1'b0);
        upd(1'b1, 1'b1);
        check("R5 skewed edge stores level", {7'b0, sda_out}, 8'h01);
        for (int i = 0; i < 5; i++) send_bit(1'b0, o);
        ack_clk(o);
        check("R5 ack after eight good bits", {7'b0, o}, 8'h00);
        send_bit(1'b1, o);
        check("R10 write address bit follows", {7'b0, o}, 8'h01);
        for (int i = 0; i < 7; i++) send_bit(1'b1, o);
        ack_clk(o);
        check("R8 ack after skew transfer", {7'b0, o}, 8'h00);
        stop_cond();

        // R1: reset mid-transfer returns the slave to idle
        start_cond();
        for (int i = 0; i < 4; i++) send_bit(1'b0, o);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset restores line", {7'b0, sda_out}, 8'h01);
        for (int i = 0; i < 9; i++) send_bit(1'b1, o);
        check("R1 idle after reset", {7'b0, sda_out}, 8'h01);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule